// File: doc/BRIEF.md
# Floppy Controller Bus Glue Decoder

This block sits between an 8-bit CPU bus and a floppy disk controller core, inside a 16 KB cartridge window. It decodes every CPU access by its full 16-bit address. Four fixed addresses near the top of the window pass straight through to the controller's register port. Two further addresses are write-only latches: one holds the head select, and the other holds the drive select and the motor control. A fourth address returns a status byte made from the controller's two request lines. Every other read is answered from a boot ROM.

The latched head, drive and motor values are fanned out to a parameterised set of drive ports. Each port is gated by a "drive present" input, so an empty slot sees all its outputs held low. The controller is told that it runs in double density. Its head-load request is handed straight back to it as head-loaded.

Reads are purely combinational from the address, chip select and read strobe. Latch writes take effect on the rising clock edge at which the write strobe is sampled.

Top module: `fdc_glue_top`

## Requirements
- R1: With cs and the address in 0x7FF8..0x7FFB, ctl_sel is 1, ctl_reg equals address bits [1:0], ctl_rd/ctl_wr follow rd/wr, ctl_wdata equals wdata, and a read returns ctl_rdata on rdata in the same cycle.
- R2: A write to 0x7FFC stores wdata bit 0 as the head. From the next cycle, drv_head[i] equals that bit for every present drive i.
- R3: A write to 0x7FFD stores wdata bit 0 as the selected drive. From the next cycle, drv_select is one-hot at that index, masked by drv_present.
- R4: wdata bit 7 of a write to 0x7FFD is the motor control. From the next cycle, drv_motor[i] equals it for every present drive, whichever drive is selected.
- R5: A read of 0x7FFF returns {~ctl_drq, ~ctl_irq, 6'b000000} on rdata.
- R6: A read of any other address (including 0x7FFC..0x7FFE) returns the ROM byte for address bits [13:0]. With i = addr[5:0], that byte is ((i*37+11) mod 256) XOR addr[13:6].
- R7: ctl_double_density is always 1.
- R8: ctl_hld_ack equals ctl_hld_req in the same cycle, with no register between them.
- R9: Writes to any address other than 0x7FFC/0x7FFD, and any write with cs low, leave the head, drive and motor values unchanged.
- R10: After reset the head, drive and motor values are 0. Any drive whose drv_present bit is 0 has drv_head, drv_motor and drv_select all 0.
- R11: With cs low, ctl_sel, ctl_rd and ctl_wr are 0 and rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Cartridge window select |
| rd | input | 1 | CPU read strobe |
| wr | input | 1 | CPU write strobe |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data |
| ctl_sel | output | 1 | Controller register port select |
| ctl_rd | output | 1 | Controller register read |
| ctl_wr | output | 1 | Controller register write |
| ctl_reg | output | 2 | Controller register index |
| ctl_wdata | output | 8 | Data to the controller |
| ctl_rdata | input | 8 | Data from the controller |
| ctl_drq | input | 1 | Controller data request, active high |
| ctl_irq | input | 1 | Controller interrupt request, active high |
| ctl_double_density | output | 1 | Density mode to the controller |
| ctl_hld_req | input | 1 | Head-load request from the controller |
| ctl_hld_ack | output | 1 | Head-loaded indication back to the controller |
| drv_present | input | 2 | Drive slot occupied, one bit per drive |
| drv_head | output | 2 | Head select per drive |
| drv_motor | output | 2 | Motor on per drive |
| drv_select | output | 2 | One-hot drive routing |

## Verification
Two functions can fall in the same cycle: a drive/motor latch write, and a change on the controller's head-load request. The bench toggles ctl_hld_req during the very cycle in which a 0x7FFD write is held on the bus. It then requires ctl_hld_ack to track the request at once, while the drive and motor outputs change only after the clock edge. A second overlap puts a status read and a change of the request lines in one cycle. The bench sweeps drq/irq along with the address and checks that the status byte follows the lines combinationally.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int REG_IDX_W = 2;

    localparam logic [ADDR_W-1:0] WIN_BASE  = 16'h7FF8;
    localparam logic [ADDR_W-1:0] HEAD_ADDR = 16'h7FFC;
    localparam logic [ADDR_W-1:0] DRV_ADDR  = 16'h7FFD;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 16'h7FFF;

    typedef enum logic [1:0] {
        SRC_ROM  = 2'd0,
        SRC_CTL  = 2'd1,
        SRC_STAT = 2'd2
    } rd_src_e;
endpackage

// File: rtl/fdc_glue_decode.sv
module fdc_glue_decode
    import fdc_glue_pkg::*;
(
    input  logic              cs,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_ctl,
    output logic              hit_head,
    output logic              hit_drv,
    output rd_src_e           rd_src
);
    logic in_win;

    always_comb begin
        in_win   = (addr[ADDR_W-1:REG_IDX_W] == WIN_BASE[ADDR_W-1:REG_IDX_W]);
        hit_ctl  = cs && in_win;
        hit_head = cs && (addr == HEAD_ADDR);
        hit_drv  = cs && (addr == DRV_ADDR);
        if (in_win)
            rd_src = SRC_CTL;
        else if (addr == STAT_ADDR)
            rd_src = SRC_STAT;
        else
            rd_src = SRC_ROM;
    end
endmodule

// File: rtl/fdc_glue_latch.sv
module fdc_glue_latch #(
    parameter int DRV_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             hit_head,
    input  logic             hit_drv,
    input  logic             head_bit,
    input  logic [DRV_W-1:0] drv_bits,
    input  logic             motor_bit,
    output logic             head,
    output logic [DRV_W-1:0] drive,
    output logic             motor
);
    typedef struct packed {
        logic             head;
        logic [DRV_W-1:0] drive;
        logic             motor;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && hit_head) begin
            st_d.head = head_bit;
        end
        if (wr && hit_drv) begin
            st_d.drive = drv_bits;
            st_d.motor = motor_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign head  = st_q.head;
    assign drive = st_q.drive;
    assign motor = st_q.motor;
endmodule

// File: rtl/fdc_glue_drive_fan.sv
module fdc_glue_drive_fan #(
    parameter int NUM_DRIVES = 2,
    parameter int DRV_W      = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic                  head,
    input  logic [DRV_W-1:0]      drive,
    input  logic                  motor,
    input  logic [NUM_DRIVES-1:0] present,
    output logic [NUM_DRIVES-1:0] head_o,
    output logic [NUM_DRIVES-1:0] motor_o,
    output logic [NUM_DRIVES-1:0] select_o
);
    for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_port
        assign head_o[i]   = present[i] & head;
        assign motor_o[i]  = present[i] & motor;
        assign select_o[i] = present[i] & (drive == DRV_W'(i));
    end
endmodule

// File: rtl/fdc_glue_rom.sv
module fdc_glue_rom #(
    parameter int ROM_AW = 14,
    parameter int TAB_AW = 6,
    parameter int DW     = 8
) (
    input  logic [ROM_AW-1:0] addr,
    output logic [DW-1:0]     data
);
    localparam int TAB_N = 1 << TAB_AW;
    localparam int HI_W  = ROM_AW - TAB_AW;

    logic [DW-1:0] tab [TAB_N];
    logic [HI_W-1:0] hi;

    for (genvar i = 0; i < TAB_N; i++) begin : g_tab
        assign tab[i] = DW'((i * 37 + 11) % 256);
    end

    assign hi   = addr[ROM_AW-1:TAB_AW];
    assign data = tab[addr[TAB_AW-1:0]] ^ DW'(hi);
endmodule

// File: rtl/fdc_glue_top.sv
module fdc_glue_top
    import fdc_glue_pkg::*;
#(
    parameter int NUM_DRIVES = 2,
    parameter int ROM_AW     = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs,
    input  logic                  rd,
    input  logic                  wr,
    input  logic [15:0]           addr,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output logic                  ctl_sel,
    output logic                  ctl_rd,
    output logic                  ctl_wr,
    output logic [1:0]            ctl_reg,
    output logic [7:0]            ctl_wdata,
    input  logic [7:0]            ctl_rdata,
    input  logic                  ctl_drq,
    input  logic                  ctl_irq,
    output logic                  ctl_double_density,
    input  logic                  ctl_hld_req,
    output logic                  ctl_hld_ack,
    input  logic [NUM_DRIVES-1:0] drv_present,
    output logic [NUM_DRIVES-1:0] drv_head,
    output logic [NUM_DRIVES-1:0] drv_motor,
    output logic [NUM_DRIVES-1:0] drv_select
);
    localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1;

    logic             hit_ctl, hit_head, hit_drv;
    rd_src_e          rd_src;
    logic             lat_head, lat_motor;
    logic [DRV_W-1:0] lat_drive;
    logic [7:0]       rom_data;
    logic [7:0]       stat_byte;

    fdc_glue_decode u_dec (
        .cs       (cs),
        .addr     (addr),
        .hit_ctl  (hit_ctl),
        .hit_head (hit_head),
        .hit_drv  (hit_drv),
        .rd_src   (rd_src)
    );

    fdc_glue_latch #(.DRV_W(DRV_W)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr),
        .hit_head  (hit_head),
        .hit_drv   (hit_drv),
        .head_bit  (wdata[0]),
        .drv_bits  (wdata[DRV_W-1:0]),
        .motor_bit (wdata[7]),
        .head      (lat_head),
        .drive     (lat_drive),
        .motor     (lat_motor)
    );

    fdc_glue_drive_fan #(.NUM_DRIVES(NUM_DRIVES), .DRV_W(DRV_W)) u_fan (
        .head     (lat_head),
        .drive    (lat_drive),
        .motor    (lat_motor),
        .present  (drv_present),
        .head_o   (drv_head),
        .motor_o  (drv_motor),
        .select_o (drv_select)
    );

    fdc_glue_rom #(.ROM_AW(ROM_AW), .TAB_AW(6), .DW(8)) u_rom (
        .addr (addr[ROM_AW-1:0]),
        .data (rom_data)
    );

    assign ctl_sel            = hit_ctl;
    assign ctl_rd             = hit_ctl && rd;
    assign ctl_wr             = hit_ctl && wr;
    assign ctl_reg            = addr[1:0];
    assign ctl_wdata          = wdata;
    assign ctl_double_density = 1'b1;
    assign ctl_hld_ack        = ctl_hld_req;
    assign stat_byte          = {~ctl_drq, ~ctl_irq, 6'b000000};

    always_comb begin
        rdata = 8'h00;
        if (cs && rd) begin
            unique case (rd_src)
                SRC_CTL:  rdata = ctl_rdata;
                SRC_STAT: rdata = stat_byte;
                default:  rdata = rom_data;
            endcase
        end
    end
endmodule

// File: rtl/fdc_glue_checker.sv
module fdc_glue_checker #(
    parameter int NUM_DRIVES = 2,
    parameter int DRV_W      = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs,
    input logic                  rd,
    input logic                  wr,
    input logic [15:0]           addr,
    input logic [7:0]            wdata,
    input logic [7:0]            rdata,
    input logic                  ctl_sel,
    input logic                  ctl_rd,
    input logic                  ctl_wr,
    input logic [1:0]            ctl_reg,
    input logic [7:0]            ctl_rdata,
    input logic                  ctl_drq,
    input logic                  ctl_irq,
    input logic                  ctl_hld_req,
    input logic                  ctl_hld_ack,
    input logic [NUM_DRIVES-1:0] drv_present,
    input logic [NUM_DRIVES-1:0] drv_head,
    input logic [NUM_DRIVES-1:0] drv_motor,
    input logic [NUM_DRIVES-1:0] drv_select,
    input logic                  lat_head,
    input logic                  lat_motor,
    input logic [DRV_W-1:0]      lat_drive
);
    a_r1_window_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && addr[15:2] == 14'h1FFE) |-> (ctl_rd && rdata == ctl_rdata && ctl_reg == addr[1:0]));

    a_r2_head_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == 16'h7FFC) |=> (lat_head == $past(wdata[0])));

    a_r4_motor_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == 16'h7FFD) |=> (lat_motor == $past(wdata[7])));

    a_r3_select_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_select));

    a_r5_status: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && addr == 16'h7FFF) |-> (rdata == {!ctl_drq, !ctl_irq, 6'b0}));

    a_r8_hld_loop: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_hld_ack == ctl_hld_req);

    a_r9_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && wr && (addr == 16'h7FFC || addr == 16'h7FFD))
        |=> ($stable(lat_head) && $stable(lat_motor) && $stable(lat_drive)));

    a_r10_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_head | drv_motor | drv_select) & ~drv_present) == '0);

    a_r11_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> (!ctl_sel && !ctl_wr && !ctl_rd && rdata == 8'h00));
endmodule

bind fdc_glue_top fdc_glue_checker #(.NUM_DRIVES(NUM_DRIVES), .DRV_W(DRV_W)) u_chk (.*);

// File: tb/fdc_glue_top_test.sv
module fdc_glue_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ctl_sel, ctl_rd, ctl_wr, ctl_double_density, ctl_hld_ack;
    logic [1:0] ctl_reg;
    logic [7:0] ctl_wdata, ctl_rdata;
    logic       ctl_drq = 1'b0, ctl_irq = 1'b0, ctl_hld_req = 1'b0;
    logic [1:0] drv_present = 2'b11;
    logic [1:0] drv_head, drv_motor, drv_select;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // controller stub: register index visible in the returned byte
    assign ctl_rdata = ctl_rd ? {4'hA, 2'b00, ctl_reg} : 8'hFF;

    fdc_glue_top uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ctl_sel(ctl_sel), .ctl_rd(ctl_rd),
        .ctl_wr(ctl_wr), .ctl_reg(ctl_reg), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .ctl_drq(ctl_drq), .ctl_irq(ctl_irq),
        .ctl_double_density(ctl_double_density), .ctl_hld_req(ctl_hld_req),
        .ctl_hld_ack(ctl_hld_ack), .drv_present(drv_present),
        .drv_head(drv_head), .drv_motor(drv_motor), .drv_select(drv_select)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rom_exp(input logic [15:0] a);
        int i;
        i = int'(a[5:0]);
        return 8'((i * 37 + 11) % 256) ^ a[13:6];
    endfunction

    function automatic logic [5:0] drv_exp(input logic h, input logic d, input logic m, input logic [1:0] p);
        logic [1:0] sel;
        sel = d ? 2'b10 : 2'b01;
        return {({2{h}} & p), ({2{m}} & p), (sel & p)};
    endfunction

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic sel);
        @(negedge clk);
        cs = sel; wr = 1'b1; rd = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [5:0] e;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk({drv_head, drv_motor, drv_select} == 6'b000001, "R10 reset",
            {drv_head, drv_motor, drv_select}, 6'b000001);
        rst_n = 1'b1;
        @(negedge clk);
        chk({drv_head, drv_motor, drv_select} == 6'b000001, "R10 after reset",
            {drv_head, drv_motor, drv_select}, 6'b000001);
        chk(ctl_double_density == 1'b1, "R7 density", ctl_double_density, 1);

        // R11 idle bus
        addr = 16'h7FF9; rd = 1'b1; wr = 1'b1; #1;
        chk(!ctl_sel && !ctl_rd && !ctl_wr && rdata == 8'h00, "R11 cs low",
            {ctl_sel, ctl_rd, ctl_wr, rdata}, 0);
        rd = 1'b0; wr = 1'b0;

        // R1 R5 R6 full address sweep of reads
        @(negedge clk);
        cs = 1'b1; rd = 1'b1;
        for (int a = 0; a < 65536; a++) begin
            logic [7:0] exp;
            addr = 16'(a);
            ctl_drq = a[0]; ctl_irq = a[1];
            #1;
            if (addr >= 16'h7FF8 && addr <= 16'h7FFB) begin
                exp = {4'hA, 2'b00, addr[1:0]};
                chk(rdata == exp && ctl_sel && ctl_reg == addr[1:0], "R1 window read", rdata, exp);
            end else if (addr == 16'h7FFF) begin
                exp = {~ctl_drq, ~ctl_irq, 6'b0};
                chk(rdata == exp, "R5 status", rdata, exp);
            end else begin
                exp = rom_exp(addr);
                chk(rdata == exp && !ctl_sel, "R6 rom read", rdata, exp);
            end
        end
        // R5 status for each request combination at fixed address
        addr = 16'h7FFF;
        for (int s = 0; s < 4; s++) begin
            ctl_drq = s[1]; ctl_irq = s[0]; #1;
            chk(rdata == {~s[1], ~s[0], 6'b0}, "R5 status combo", rdata, {~s[1], ~s[0], 6'b0});
        end
        cs = 1'b0; rd = 1'b0;

        // R1 controller writes
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            cs = 1'b1; wr = 1'b1; addr = 16'h7FF8 + 16'(r); wdata = 8'(8'h30 + r); #1;
            chk(ctl_wr && !ctl_rd && ctl_reg == 2'(r) && ctl_wdata == 8'(8'h30 + r),
                "R1 window write", {ctl_wr, ctl_reg, ctl_wdata}, {1'b1, 2'(r), 8'(8'h30 + r)});
            @(negedge clk);
            cs = 1'b0; wr = 1'b0;
        end

        // R2 R3 R4 R10 latch sweeps over presence
        for (int p = 0; p < 4; p++) begin
            drv_present = 2'(p);
            for (int h = 0; h < 2; h++) begin
                bus_write(16'h7FFC, {7'h55, h[0]}, 1'b1);
                e = drv_exp(h[0], 1'b0, 1'b0, 2'(p));
                chk(drv_head == e[5:4], "R2 head", drv_head, e[5:4]);
            end
            bus_write(16'h7FFC, 8'h00, 1'b1);
            for (int d = 0; d < 256; d++) begin
                bus_write(16'h7FFD, 8'(d), 1'b1);
                e = drv_exp(1'b0, d[0], d[7], 2'(p));
                chk(drv_select == e[1:0], "R3 drive select", drv_select, e[1:0]);
                chk(drv_motor == e[3:2], "R4 motor", drv_motor, e[3:2]);
                chk(drv_head == 2'b00, "R10 head held", drv_head, 0);
            end
        end

        // R9 ignored writes
        drv_present = 2'b11;
        bus_write(16'h7FFC, 8'h01, 1'b1);
        bus_write(16'h7FFD, 8'h81, 1'b1);
        for (int k = 0; k < 260; k++) begin
            logic [15:0] wa;
            if (k < 256)      wa = 16'(k * 256 + 16'h0012);
            else if (k < 258) wa = 16'h7FFE + 16'(k - 256);
            else              wa = 16'h7FF8 + 16'(k - 258);
            bus_write(wa, 8'h00, 1'b1);
            chk({drv_head, drv_motor, drv_select} == 6'b111110, "R9 stray write",
                {drv_head, drv_motor, drv_select}, 6'b111110);
        end
        bus_write(16'h7FFC, 8'h00, 1'b0);
        bus_write(16'h7FFD, 8'h00, 1'b0);
        chk({drv_head, drv_motor, drv_select} == 6'b111110, "R9 cs low write",
            {drv_head, drv_motor, drv_select}, 6'b111110);

        // R8 loop-back, coinciding with a drive/motor write
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = 16'h7FFD; wdata = 8'h00;
        ctl_hld_req = 1'b1; #1;
        chk(ctl_hld_ack == 1'b1, "R8 hld rise", ctl_hld_ack, 1);
        chk(drv_motor == 2'b11, "R4 before edge", drv_motor, 2'b11);
        @(posedge clk); #1;
        ctl_hld_req = 1'b0; #1;
        chk(ctl_hld_ack == 1'b0, "R8 hld fall", ctl_hld_ack, 0);
        chk(drv_motor == 2'b00 && drv_select == 2'b01, "R3 after edge",
            {drv_motor, drv_select}, 4'b0001);
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule